// File: doc/BRIEF.md
# Multi-Bus Fixed-Priority Result Arbiter

This block sits between the execution units of an out-of-order core and its shared result broadcast buses. Six functional-unit classes can each raise a request when they have a finished result. Each request carries a destination tag and a value. The number of broadcast buses is a parameter. In every cycle the arbiter grants up to that many requesters at once, in a fixed ranking by unit class, and places each granted result on its own bus.

Branch outcomes are sent over these same shared buses. Store effective addresses take a separate path to the reorder buffer, so the load/store class raises a request only for load results. A requester that is not granted keeps its request raised and tries again in a later cycle.

The grants are combinational from the request vector, so a unit sees its grant in the same cycle it asks. The buses are registered, so a broadcast is visible one clock after its grant. Each bus has a saturating counter of the cycles in which it carried a broadcast. Dividing that count by the total cycle count gives the bus utilisation.

Top module: `rba_result_arbiter`

## Requirements
- R1: Request bit positions give the fixed ranking, highest first: bit 0 branch unit, bit 1 divider, bit 2 load/store unit, bit 3 multiplier, bit 4 floating-point adder, bit 5 integer ALU. When the number of raised requests is at most NUM_BUS, every raised request is granted in the same cycle.
- R2: When more requests are raised than there are buses, exactly NUM_BUS are granted: the highest-ranked ones. A lower-ranked request is never granted while a higher-ranked raised request is left out.
- R3: The k-th highest-ranked granted request (k counted from 0) is assigned to bus k. Each bus takes at most one request per cycle.
- R4: Bus outputs are registered. At the clock edge that ends the grant cycle, bus k loads the tag and value of the request assigned to it and raises its valid bit.
- R5: A bus with no assigned request in the previous cycle drives valid low, with tag and value both zero.
- R6: Each bus has a CNT_W-bit counter. It increments by one for every cycle in which that bus's valid bit is high, and it holds at all ones once it reaches that value.
- R7: A synchronous active-low reset clears every bus valid bit, tag, value and counter. Reset takes priority over raised requests.
- R8: With NUM_BUS = 1, when the integer ALU and the divider request together, only the divider is granted, and the divider's result appears on bus 0.
- R9: A grant is never raised for a class whose request bit is low. An ungranted request produces no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 6 | Result-ready request, one bit per unit class (bit order as in R1) |
| tag_i | input | 6*TAG_W | Destination tag per class; class i at bits [i*TAG_W +: TAG_W] |
| data_i | input | 6*DATA_W | Result value per class; class i at bits [i*DATA_W +: DATA_W] |
| grant_o | output | 6 | Combinational grant, one bit per unit class |
| bus_valid_o | output | NUM_BUS | Broadcast valid per bus |
| bus_tag_o | output | NUM_BUS*TAG_W | Broadcast tag; bus k at bits [k*TAG_W +: TAG_W] |
| bus_data_o | output | NUM_BUS*DATA_W | Broadcast value; bus k at bits [k*DATA_W +: DATA_W] |
| bus_count_o | output | NUM_BUS*CNT_W | Broadcast-cycle counter; bus k at bits [k*CNT_W +: CNT_W] |

## Verification
The assertions check several rules on every cycle:
- no grant is raised without a request, and the number of grants never exceeds the bus count;
- the granted set always forms a prefix of the ranking, and every request is granted when there are enough buses;
- a bus is valid exactly when the previous cycle had more grants than that bus's index;
- idle buses carry zeros, and each counter moves only with its bus's valid bit.

The bench scenarios are needed to show the results that depend on actual values: which tag and value land on which bus, the one-bus case with the ALU and the divider, counter saturation, and reset overriding live requests.

// File: rtl/rba_pkg.sv
// Shared constants and the unit-class ranking for the result arbiter.
// Assumes exactly six unit classes; the enum value is the request bit
// position and also the priority rank (0 is highest).
package rba_pkg;

    localparam int NUM_CLASSES = 6;
    localparam int RANK_W      = $clog2(NUM_CLASSES + 1);

    typedef enum logic [2:0] {
        CLS_BRANCH   = 3'd0,
        CLS_DIVIDE   = 3'd1,
        CLS_MEMORY   = 3'd2,
        CLS_MULTIPLY = 3'd3,
        CLS_FPADD    = 3'd4,
        CLS_INTALU   = 3'd5
    } fu_class_e;

endpackage

// File: rtl/rba_rank_select.sv
// Ranks raised requests and maps them onto buses.
// Each raised request gets a rank equal to the number of higher-ranked
// raised requests. Rank k goes to bus k when k < NUM_BUS. The grant and
// bus-select outputs are purely combinational. clk and rst_n feed only
// the assertions.
module rba_rank_select
    import rba_pkg::*;
#(
    parameter int NUM_BUS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CLASSES-1:0]         req_i,
    output logic [NUM_CLASSES-1:0]         grant_o,
    output logic [NUM_BUS*NUM_CLASSES-1:0] sel_o
);

    localparam int              CAP   = (NUM_BUS < NUM_CLASSES) ? NUM_BUS : NUM_CLASSES;
    localparam logic [RANK_W-1:0] CAP_R = RANK_W'(CAP);

    logic [RANK_W-1:0] rank [NUM_CLASSES];

    // Running count of higher-ranked requests gives each class its rank.
    always_comb begin
        logic [RANK_W-1:0] run;
        run = '0;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            rank[i] = run;
            run     = run + RANK_W'(req_i[i]);
        end
    end

    genvar gi, gb;
    generate
        for (gi = 0; gi < NUM_CLASSES; gi++) begin : g_grant
            assign grant_o[gi] = req_i[gi] && (rank[gi] < CAP_R);
        end

        for (gb = 0; gb < NUM_BUS; gb++) begin : g_bus
            for (gi = 0; gi < NUM_CLASSES; gi++) begin : g_cls
                if (gb < NUM_CLASSES) begin : g_live
                    assign sel_o[gb*NUM_CLASSES + gi] = req_i[gi] && (rank[gi] == RANK_W'(gb));
                end else begin : g_idle
                    assign sel_o[gb*NUM_CLASSES + gi] = 1'b0;
                end
            end

            // R3
            bus_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(sel_o[gb*NUM_CLASSES +: NUM_CLASSES]));
        end

        for (gi = 1; gi < NUM_CLASSES; gi++) begin : g_prefix
            // R2
            rank_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant_o[gi] |-> ((req_i[gi-1:0] & ~grant_o[gi-1:0]) == '0));
        end
    endgenerate

    // R9
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    // R2
    grant_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= NUM_BUS);

    // R1
    all_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req_i) <= NUM_BUS) |-> (grant_o == req_i));

endmodule

// File: rtl/rba_bus_lane.sv
// One broadcast bus: an AND-OR mux over the class results, then a register.
// Assumes sel_i is one-hot or zero. With sel_i zero the bus loads valid low
// and zero payload.
module rba_bus_lane
    import rba_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CLASSES-1:0]        sel_i,
    input  logic [NUM_CLASSES*TAG_W-1:0]  tag_i,
    input  logic [NUM_CLASSES*DATA_W-1:0] data_i,
    output logic                          valid_o,
    output logic [TAG_W-1:0]              tag_o,
    output logic [DATA_W-1:0]             data_o
);

    logic [TAG_W-1:0]  tag_n;
    logic [DATA_W-1:0] data_n;

    // Select the payload of the class assigned to this bus.
    always_comb begin
        tag_n  = '0;
        data_n = '0;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            tag_n  = tag_n  | ({TAG_W{sel_i[i]}}  & tag_i[i*TAG_W +: TAG_W]);
            data_n = data_n | ({DATA_W{sel_i[i]}} & data_i[i*DATA_W +: DATA_W]);
        end
    end

    // Register the broadcast so it appears one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
            data_o  <= '0;
        end else begin
            valid_o <= |sel_i;
            tag_o   <= tag_n;
            data_o  <= data_n;
        end
    end

endmodule

// File: rtl/rba_bus_counter.sv
// Saturating count of the cycles in which one bus carries a broadcast.
// bump_i must be high on the edge where the bus loads a valid result, so
// the count already includes the broadcast currently shown on the bus.
module rba_bus_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    output logic [CNT_W-1:0] count_o
);

    // Count broadcast cycles; hold at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (bump_i && (count_o != '1)) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/rba_result_arbiter.sv
// Top level of the multi-bus fixed-priority result arbiter.
// Grants up to NUM_BUS of the six unit classes in each cycle, in fixed rank
// order, and registers each granted result onto its own bus. Every bus has
// a saturating broadcast counter. Requesters that are not granted must keep
// their request raised.
module rba_result_arbiter
    import rba_pkg::*;
#(
    parameter int NUM_BUS = 2,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CLASSES-1:0]        req_i,
    input  logic [NUM_CLASSES*TAG_W-1:0]  tag_i,
    input  logic [NUM_CLASSES*DATA_W-1:0] data_i,
    output logic [NUM_CLASSES-1:0]        grant_o,
    output logic [NUM_BUS-1:0]            bus_valid_o,
    output logic [NUM_BUS*TAG_W-1:0]      bus_tag_o,
    output logic [NUM_BUS*DATA_W-1:0]     bus_data_o,
    output logic [NUM_BUS*CNT_W-1:0]      bus_count_o
);

    logic [NUM_BUS*NUM_CLASSES-1:0] sel;

    rba_rank_select #(
        .NUM_BUS (NUM_BUS)
    ) u_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .grant_o (grant_o),
        .sel_o   (sel)
    );

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BUS; gb++) begin : g_bus
            rba_bus_lane #(
                .TAG_W  (TAG_W),
                .DATA_W (DATA_W)
            ) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel_i   (sel[gb*NUM_CLASSES +: NUM_CLASSES]),
                .tag_i   (tag_i),
                .data_i  (data_i),
                .valid_o (bus_valid_o[gb]),
                .tag_o   (bus_tag_o[gb*TAG_W +: TAG_W]),
                .data_o  (bus_data_o[gb*DATA_W +: DATA_W])
            );

            rba_bus_counter #(
                .CNT_W (CNT_W)
            ) u_count (
                .clk     (clk),
                .rst_n   (rst_n),
                .bump_i  (|sel[gb*NUM_CLASSES +: NUM_CLASSES]),
                .count_o (bus_count_o[gb*CNT_W +: CNT_W])
            );

            // R4
            bus_valid_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (bus_valid_o[gb] == ($past($countones(grant_o)) > gb)));

            // R5
            idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !bus_valid_o[gb] |-> ((bus_tag_o[gb*TAG_W +: TAG_W] == '0) &&
                                      (bus_data_o[gb*DATA_W +: DATA_W] == '0)));

            // R6
            count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && bus_valid_o[gb] && ($past(bus_count_o[gb*CNT_W +: CNT_W]) != '1))
                |-> (bus_count_o[gb*CNT_W +: CNT_W] == $past(bus_count_o[gb*CNT_W +: CNT_W]) + 1'b1));

            // R6
            count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !bus_valid_o[gb]) |-> $stable(bus_count_o[gb*CNT_W +: CNT_W]));
        end
    endgenerate

    // R4
    top_class_on_bus0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_i[CLS_BRANCH]))
        |-> ((bus_tag_o[TAG_W-1:0] == $past(tag_i[TAG_W-1:0])) &&
             (bus_data_o[DATA_W-1:0] == $past(data_i[DATA_W-1:0]))));

endmodule

// File: tb/sim_rba_result_arbiter.sv
// Bench: table-driven grant and bus checks, then directed reset, idle,
// single-bus and saturation cases.
module sim_rba_result_arbiter;

    localparam int NC     = 6;
    localparam int NB     = 2;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int CNT1_W = 3;
    localparam int NVEC   = 10;

    // {request vector, expected grant with two buses}; bit 0 branch .. bit 5 ALU
    localparam logic [11:0] VEC [NVEC] = '{
        {6'b000000, 6'b000000},
        {6'b100010, 6'b100010},
        {6'b111111, 6'b000011},
        {6'b111100, 6'b001100},
        {6'b100001, 6'b100001},
        {6'b010100, 6'b010100},
        {6'b101011, 6'b000011},
        {6'b111000, 6'b011000},
        {6'b100000, 6'b100000},
        {6'b001110, 6'b000110}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NC-1:0]        req = '0;
    logic [NC*TAG_W-1:0]  tag = '0;
    logic [NC*DATA_W-1:0] data = '0;

    logic [NC-1:0]        grant0, grant1;
    logic [NB-1:0]        valid0;
    logic [NB*TAG_W-1:0]  btag0;
    logic [NB*DATA_W-1:0] bdata0;
    logic [NB*CNT_W-1:0]  cnt0;
    logic [0:0]           valid1;
    logic [TAG_W-1:0]     btag1;
    logic [DATA_W-1:0]    bdata1;
    logic [CNT1_W-1:0]    cnt1;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rba_result_arbiter #(.NUM_BUS(NB), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tag_i(tag), .data_i(data),
        .grant_o(grant0), .bus_valid_o(valid0), .bus_tag_o(btag0),
        .bus_data_o(bdata0), .bus_count_o(cnt0));

    rba_result_arbiter #(.NUM_BUS(1), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT1_W)) u1 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tag_i(tag), .data_i(data),
        .grant_o(grant1), .bus_valid_o(valid1), .bus_tag_o(btag1),
        .bus_data_o(bdata1), .bus_count_o(cnt1));

    function automatic logic [TAG_W-1:0] tag_of(int v, int c);
        return TAG_W'(v * 7 + c * 3 + 1);
    endfunction

    function automatic logic [DATA_W-1:0] data_of(int v, int c);
        return 32'hC0DE_0000 + DATA_W'(v * 256 + c);
    endfunction

    // index of the n-th set bit from bit 0, or -1
    function automatic int nth_set(logic [NC-1:0] g, int n);
        int seen = 0;
        for (int i = 0; i < NC; i++) begin
            if (g[i]) begin
                if (seen == n) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive(input int v, input logic [NC-1:0] r);
        req = r;
        for (int c = 0; c < NC; c++) begin
            tag[c*TAG_W +: TAG_W]    = tag_of(v, c);
            data[c*DATA_W +: DATA_W] = data_of(v, c);
        end
    endtask

    // Checks both buses of u0 against the grant expected for vector v.
    task automatic check_buses(input int v, input logic [NC-1:0] g);
        for (int b = 0; b < NB; b++) begin
            int c = nth_set(g, b);
            if (c < 0) begin
                check(valid0[b] == 1'b0 && btag0[b*TAG_W +: TAG_W] == '0 &&
                      bdata0[b*DATA_W +: DATA_W] == '0,
                      "R5 idle bus", {63'd0, valid0[b]}, 64'd0);
            end else begin
                check(valid0[b] == 1'b1, "R4 bus valid", {63'd0, valid0[b]}, 64'd1);
                check(btag0[b*TAG_W +: TAG_W] == tag_of(v, c), "R3 bus tag",
                      64'(btag0[b*TAG_W +: TAG_W]), 64'(tag_of(v, c)));
                check(bdata0[b*DATA_W +: DATA_W] == data_of(v, c), "R4 bus data",
                      64'(bdata0[b*DATA_W +: DATA_W]), 64'(data_of(v, c)));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(valid0 == '0 && cnt0 == '0 && valid1 == '0 && cnt1 == '0,
              "R7 reset state", 64'(valid0), 64'd0);
        rst_n = 1'b1;

        // Table walk: grant the same cycle (R1, R2, R9), bus one cycle later.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            if (v > 0) check_buses(v - 1, VEC[v-1][5:0]);
            drive(v, VEC[v][11:6]);
            #1;
            check(grant0 == VEC[v][5:0], "R2 grant vector",
                  64'(grant0), 64'(VEC[v][5:0]));
        end
        @(negedge clk);
        check_buses(NVEC - 1, VEC[NVEC-1][5:0]);
        drive(0, '0);

        // R6: broadcast-cycle counts, and saturation on the 3-bit counter
        check(cnt0[CNT_W-1:0] == 16'd9, "R6 bus0 count", 64'(cnt0[CNT_W-1:0]), 64'd9);
        check(cnt0[2*CNT_W-1:CNT_W] == 16'd8, "R6 bus1 count", 64'(cnt0[2*CNT_W-1:CNT_W]), 64'd8);
        check(cnt1 == 3'd7, "R6 saturated count", 64'(cnt1), 64'd7);

        // R5: idle after requests drop; counts hold
        @(negedge clk);
        check(valid0 == '0 && btag0 == '0 && bdata0 == '0, "R5 idle buses", 64'(valid0), 64'd0);
        check(cnt0[CNT_W-1:0] == 16'd9, "R6 count holds", 64'(cnt0[CNT_W-1:0]), 64'd9);

        // R8: one bus, integer ALU and divider together
        drive(20, 6'b100010);
        #1;
        check(grant1 == 6'b000010, "R8 single-bus grant", 64'(grant1), 64'h2);
        @(negedge clk);
        check(valid1 == 1'b1 && btag1 == tag_of(20, 1), "R8 divider on bus 0",
              64'(btag1), 64'(tag_of(20, 1)));
        check(bdata1 == data_of(20, 1), "R8 divider data", 64'(bdata1), 64'(data_of(20, 1)));

        // R1: held leftover ALU request alone gets through on the next cycle
        drive(21, 6'b100000);
        #1;
        check(grant1 == 6'b100000, "R1 held request granted", 64'(grant1), 64'h20);

        // R7: reset overrides live requests
        drive(22, 6'b111111);
        rst_n = 1'b0;
        @(negedge clk);
        check(valid0 == '0 && btag0 == '0 && cnt0 == '0 && valid1 == '0 && cnt1 == '0,
              "R7 reset over requests", 64'(cnt0), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid0 == 2'b11 && btag0[TAG_W-1:0] == tag_of(22, 0),
              "R4 broadcast after reset", 64'(btag0[TAG_W-1:0]), 64'(tag_of(22, 0)));
        drive(0, '0);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule